// File: doc/BRIEF.md
# Fault Interrupt and Reset Aggregator

This block gathers fault pulses from six monitor sources into sticky flags and turns them into two active-low pins: an interrupt line and a system reset line. Every fault raises the interrupt. Only the faults that threaten safe operation also pull the reset line: emergency power-down, enable-pin readback, regulator and over-temperature. The pin-readback fault and the runtime checksum fault only interrupt. A summary bit records that any fault has arrived. Software clears flags by writing ones to them.

A small register port gives software three things. It can read and clear the flags. It can set a force bit that pulls the interrupt low with no fault present. It can pick a reset hold delay from a 4-bit code. The reset line stays low while any reset-class flag is set. It is released only after the chosen delay has run out with no such flag pending. A read-only word reports the present level of both pins.

Top module: `fault_irq_rst_agg`

## Requirements
- R1: A fault pulse on `fault_i[k]` sets flag k, which is bit k of the word at address 0. The flag then stays set until software clears it. Bit 0 is emergency power-down, bit 1 enable-pin fault, bit 2 regulator fault, bit 3 thermal fault, bit 4 pin-readback fault and bit 5 runtime checksum fault.
- R2: A write to address 0 clears exactly those flag bits (6:0) whose write-data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: When a fault pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R4: Bit 6 at address 0 is the summary bit. It is set in the cycle after any fault pulse and is cleared only by writing 1 to bit 6.
- R5: `irq_no` is low in the cycle after any flag bit 6:0 becomes set. It goes high again once all flags and the force bit are clear.
- R6: The force bit (address 1, bit 0) holds `irq_no` low regardless of the flags. When the force bit is clear, `irq_no` follows the flags.
- R7: A set flag in bits 0 to 3 drives `rst_no` low one cycle after the flag appears.
- R8: Flags 4 and 5 never change `rst_no`.
- R9: `rst_no` returns high after (2^code) x TICK_DIV cycles in a row with no flag in bits 0 to 3 set. The code is the delay field at address 1, bits 7:4. Any such flag restarts the count.
- R10: After the block reset, all flags and controls are 0 and `irq_no` is high. `rst_no` is held low for TICK_DIV cycles, which is the code-0 delay.
- R11: Address 2 reads the present `irq_no` level on bit 0 and the present `rst_no` level on bit 1. All other bits read 0.
- R12: Address 1 reads back the force bit on bit 0 and the delay code on bits 7:4, with bits 3:1 reading 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| fault_i | input | 6 | Fault pulses, one per monitor source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_no | output | 1 | Active-low interrupt pin |
| rst_no | output | 1 | Active-low system reset pin |

## Verification
The bench first drives the main function with single isolated pulses from each fault class. This separates the interrupt-only sources from the reset-class ones. It then tries write-1 clears with zero, partial and full masks. It also makes a pulse and a clear meet on the same bit, which tells set priority apart from clear priority. A second reset-class pulse arrives partway through a countdown, and a later release uses a long delay code. These patterns tell a restarting timer apart from one that only counts total fault-free time. Last, a pseudo-random mix of pulses and clears exercises flag interactions that the directed cases do not reach.

// File: rtl/fira_pkg.sv
package fira_pkg;
  localparam int NFLT    = 6;
  localparam int FLAG_W  = NFLT + 1;
  localparam int SUM_BIT = NFLT;
  localparam logic [NFLT-1:0] RST_CLASS = 6'b001111;
  localparam int DLY_LSB = 4;

  typedef enum logic [1:0] {
    A_FLAGS = 2'd0,
    A_CTRL  = 2'd1,
    A_STAT  = 2'd2,
    A_RSVD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fira_flag_bank.sv
module fira_flag_bank #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] flags_nxt_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_comb begin
      flags_d[k] = flags_q[k];
      if (clr_i[k]) flags_d[k] = 1'b0;
      if (set_i[k]) flags_d[k] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[k] <= 1'b0;
      else         flags_q[k] <= flags_d[k];
    end
  end

  assign flags_o     = flags_q;
  assign flags_nxt_o = flags_d;
endmodule

// File: rtl/fira_rst_timer.sv
module fira_rst_timer #(
  parameter int DLY_W    = 4,
  parameter int TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             hold_o
);
  localparam int CNT_W = (1 << DLY_W) - 1;
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             tick;
  logic [CNT_W:0]   lim_full;
  logic             done;

  assign tick     = hold_q && (pre_q == PRE_LAST);
  assign lim_full = (CNT_W + 1)'(1) << dly_i;
  assign done     = ({1'b0, cnt_q} >= (lim_full - 1'b1));

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    if (pend_i) begin
      hold_d = 1'b1;
      cnt_d  = '0;
      pre_d  = '0;
    end else if (hold_q) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (done) hold_d = 1'b0;
        else      cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/fault_irq_rst_agg.sv
module fault_irq_rst_agg #(
  parameter int DLY_W    = 4,
  parameter int TICK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] fault_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_no,
  output logic       rst_no
);
  import fira_pkg::*;

  logic [FLAG_W-1:0] flags_q, flags_nxt, set_vec, clr_vec;
  logic              force_q, force_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              ctrl_we, flag_we;
  logic              irq_q, irq_d;
  logic              hold;

  assign flag_we = wr_en_i && (addr_i == A_FLAGS);
  assign ctrl_we = wr_en_i && (addr_i == A_CTRL);
  assign set_vec = {|fault_i, fault_i};
  assign clr_vec = flag_we ? wdata_i[FLAG_W-1:0] : '0;

  fira_flag_bank #(.W(FLAG_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .flags_o    (flags_q),
    .flags_nxt_o(flags_nxt)
  );

  always_comb begin
    force_d = force_q;
    dly_d   = dly_q;
    if (ctrl_we) begin
      force_d = wdata_i[0];
      dly_d   = wdata_i[DLY_LSB +: DLY_W];
    end
    irq_d = (|flags_nxt) | force_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= 1'b0;
      dly_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      force_q <= force_d;
      dly_q   <= dly_d;
      irq_q   <= irq_d;
    end
  end

  fira_rst_timer #(.DLY_W(DLY_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(|(flags_q[NFLT-1:0] & RST_CLASS)),
    .dly_i (dly_q),
    .hold_o(hold)
  );

  assign irq_no = ~irq_q;
  assign rst_no = ~hold;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_FLAGS: rdata_o[FLAG_W-1:0] = flags_q;
      A_CTRL: begin
        rdata_o[0]                 = force_q;
        rdata_o[DLY_LSB +: DLY_W]  = dly_q;
      end
      A_STAT:  rdata_o[1:0] = {rst_no, irq_no};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fira_checker.sv
module fira_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] fault_i,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_no,
  input logic       rst_no,
  input logic [6:0] flags_q,
  input logic       force_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar k = 0; k < 7; k++) begin : g_sticky
    a_r1_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(flags_q[k]) && !$past(wr_en_i && addr_i == 2'd0 && wdata_i[k]))
      |-> flags_q[k]);
  end

  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (($past(fault_i) & ~flags_q[5:0]) == 6'b0));

  a_r4_summary_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(|fault_i)) |-> flags_q[6]);

  a_r5_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags_q) |-> !irq_no);

  a_r5_irq_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == 7'b0 && !force_q) |-> irq_no);

  a_r6_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |-> !irq_no);

  a_r7_rst_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags_q[3:0]) |=> !rst_no);

  a_r9_clean_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(rst_no)) |-> ($past(flags_q[3:0]) == 4'b0));

  a_r11_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd2) |-> (rdata_o == {6'b0, rst_no, irq_no}));
endmodule

bind fault_irq_rst_agg fira_checker chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fault_i(fault_i),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_no (irq_no),
  .rst_no (rst_no),
  .flags_q(flags_q),
  .force_q(force_q)
);

// File: tb/fault_irq_rst_agg_tb_top.sv
module fault_irq_rst_agg_tb_top;
  localparam int TDIV = 3;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [5:0] fault;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_n, rst_n;

  int    vectors = 0;
  int    errors  = 0;
  string cur     = "R10";

  always #4 clk = ~clk;

  fault_irq_rst_agg #(.DLY_W(4), .TICK_DIV(TDIV)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .fault_i(fault),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_no (irq_n),
    .rst_no (rst_n)
  );

  // behavioural reference
  bit [6:0] m_flags;
  bit       m_force;
  int       m_dly;
  bit       m_hold;
  int       m_el;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flags = '0; m_force = 0; m_dly = 0; m_hold = 1; m_el = 0;
    end else begin
      bit       pend;
      int       lim;
      bit [6:0] clr, nf;
      pend = |m_flags[3:0];
      lim  = (1 << m_dly) * TDIV;
      clr  = (wr_en && addr == 2'd0) ? wdata[6:0] : 7'b0;
      nf   = (m_flags & ~clr) | {|fault, fault};
      if (wr_en && addr == 2'd1) begin
        m_force = wdata[0];
        m_dly   = int'(wdata[7:4]);
      end
      if (pend) begin
        m_hold = 1; m_el = 0;
      end else if (m_hold) begin
        m_el++;
        if (m_el >= lim) m_hold = 0;
      end
      m_flags = nf;
    end
  end

  task automatic compare();
    bit       e_irq, e_rst;
    bit [7:0] e_rd;
    e_irq = !((|m_flags) || m_force);
    e_rst = !m_hold;
    case (addr)
      2'd0:    e_rd = {1'b0, m_flags};
      2'd1:    e_rd = {4'(m_dly), 3'b0, m_force};
      2'd2:    e_rd = {6'b0, e_rst, e_irq};
      default: e_rd = 8'h00;
    endcase
    vectors++;
    if (irq_n !== e_irq || rst_n !== e_rst || rdata !== e_rd) begin
      errors++;
      $display("FAIL %s: irq_n=%0b exp %0b, rst_n=%0b exp %0b, rdata=%h exp %h",
               cur, irq_n, e_irq, rst_n, e_rst, rdata, e_rd);
    end
  endtask

  task automatic step(input logic [5:0] f, input logic we,
                      input logic [1:0] a, input logic [7:0] wd);
    @(negedge clk);
    fault = f; wr_en = we; addr = a; wdata = wd;
    #1;
    compare();
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) step(6'b0, 1'b0, a, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni = 1'b0; fault = '0; wr_en = 0; addr = 2'd2; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    cur = "R10"; idle(6, 2'd2);           // reset hold of TDIV cycles
    cur = "R12"; step(0, 1, 2'd1, 8'h2E); // dly=2, force=0, bits 3:1 ignored
    idle(1, 2'd1);
    step(0, 1, 2'd2, 8'hFF); step(0, 1, 2'd3, 8'hFF);
    idle(1, 2'd1); idle(1, 2'd0);

    cur = "R8";  step(6'b010000, 0, 2'd2, 0); idle(8, 2'd2);
    cur = "R2";  step(0, 1, 2'd0, 8'h00); idle(1, 2'd0);
    step(0, 1, 2'd0, 8'h10); idle(1, 2'd0);
    cur = "R4";  step(0, 1, 2'd0, 8'h40); idle(2, 2'd2);

    cur = "R7";  step(6'b001000, 0, 2'd2, 0); idle(10, 2'd2);
    cur = "R1";  idle(3, 2'd0);
    cur = "R9";  step(0, 1, 2'd0, 8'h7F); idle(6, 2'd2);
    step(6'b000001, 0, 2'd2, 0); idle(3, 2'd2);   // restart mid count
    step(0, 1, 2'd0, 8'h41); idle(16, 2'd2);

    cur = "R3";  step(6'b000010, 1, 2'd0, 8'h02); idle(2, 2'd0);
    step(0, 1, 2'd0, 8'h42); idle(16, 2'd2);

    cur = "R6";  step(0, 1, 2'd1, 8'h21); idle(4, 2'd2);
    step(0, 1, 2'd1, 8'h20); idle(2, 2'd2);

    cur = "R4";  step(6'b100000, 0, 2'd0, 0); step(0, 1, 2'd0, 8'h20);
    idle(2, 2'd0); cur = "R5"; idle(1, 2'd2);
    step(0, 1, 2'd0, 8'h40); idle(2, 2'd2);

    cur = "R11"; step(6'b000100, 0, 2'd2, 0); idle(3, 2'd2);
    step(0, 1, 2'd0, 8'h44); idle(14, 2'd2);

    cur = "R9";  step(0, 1, 2'd1, 8'h50); idle(1, 2'd2); // dly=5
    step(6'b000100, 0, 2'd2, 0); idle(2, 2'd2);
    step(0, 1, 2'd0, 8'h7F); idle(100, 2'd2);
    step(0, 1, 2'd1, 8'h20); idle(2, 2'd2);

    cur = "R1";  lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [5:0] f;
      logic       we;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      f  = (lfsr[3:0] == 4'd0) ? 6'(1 << (lfsr[6:4] % 6)) : 6'b0;
      we = (lfsr[9:8] == 2'd0);
      step(f, we, we ? 2'd0 : {lfsr[11], 1'b0}, {1'b0, lfsr[15:9]});
    end
    step(0, 1, 2'd0, 8'h7F); idle(20, 2'd2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule